// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column addresses of one synchronous DRAM burst, one address per accepted beat. It can sit inside a memory model, where it stands for the device's internal column counter. It can also sit in a controller that has to follow the order in which the device will move data. A mode strobe captures the burst length and the wrap order. A start strobe gives the first column. From then on the block walks the burst in sequential or interleaved order, or runs on through every column of the row in full-page mode until a terminate pulse ends it.

The address stream leaves on a valid/ready interface. The block raises `col_valid_o` once it has an address. While `col_ready_i` is low, the address, the last flag and the valid flag all hold still. A beat counts as accepted on any clock edge where valid and ready are both high. The block cannot be held back at its inputs: the start, mode and terminate strobes are plain single-cycle pulses and take effect on the edge where they are sampled.

Top module: `burst_col_gen`

## Requirements
- R1: After reset `col_valid_o` and `col_last_o` are low, and the mode holds length code 0 with sequential order.
- R2: The length pins (code 0, 1, 2, 3 give 1, 2, 4, 8 beats; code 7 gives full page; codes 4 to 6 act as one beat) and the order pin (0 sequential, 1 interleave) are captured only on a cycle with `mode_set_i` high. A burst uses the settings captured before its start.
- R3: On the edge that samples `start_i` high, the next cycle shows `col_valid_o` high with `col_addr_o` equal to the sampled `start_col_i`.
- R4: In sequential order with length BL, beat n shows the low log2(BL) bits of the start column plus n, modulo BL. The upper column bits stay those of the start column.
- R5: In interleave order with length BL, beat n shows the start column XOR n. Only the low log2(BL) bits change.
- R6: A one-beat burst shows exactly one address, and `col_last_o` is high with it, in either order.
- R7: `col_last_o` is high only with the final beat of a fixed-length burst. After that beat is accepted, `col_valid_o` is low on the next cycle unless a new start was sampled.
- R8: While `col_valid_o` is high and `col_ready_i` is low, the address, the last flag and the valid flag hold their values on the next cycle, unless a start or a full-page terminate is sampled.
- R9: A full-page burst steps sequentially through all 256 columns whatever the order pin says. It wraps from column 255 to 0 and never raises `col_last_o`.
- R10: `term_i` ends a full-page burst, so `col_valid_o` is low the next cycle whatever the state of `col_ready_i`. During a fixed-length burst `term_i` has no effect.
- R11: A start sampled during a burst restarts the sequence from the new column. It takes priority over a terminate sampled on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_set_i | input | 1 | Captures the length and order pins |
| mode_len_i | input | 3 | Burst length code |
| mode_ilv_i | input | 1 | Wrap order: 0 sequential, 1 interleave |
| start_i | input | 1 | Begins a burst at `start_col_i` |
| start_col_i | input | COL_W | First column of the burst |
| term_i | input | 1 | Ends a full-page burst |
| col_valid_o | output | 1 | An address is offered |
| col_ready_i | input | 1 | The consumer takes the offered address |
| col_addr_o | output | COL_W | Column address of the current beat |
| col_last_o | output | 1 | Final beat of a fixed-length burst |

## Verification
The bench starts bursts at columns whose low bits are not zero. A generator that let the carry run into the upper column bits, or that confused sequential with interleave order, would therefore print a wrong address on the first wrap. A full-page burst starting at 0xFD with the interleave pin set checks both the 255-to-0 wrap and that the order pin is ignored in this mode; a design that honoured the pin or stopped at 255 would show 0xFC or go idle. A stall placed on a middle beat exposes a counter that advances without ready. A terminate during a fixed burst, a restart paired with a terminate, and mode pins changed without the strobe catch, in turn: a burst cut short, a burst that goes idle instead of restarting, and a length read live from the pins.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

  // Burst length codes as seen on the mode pins
  localparam logic [2:0] LEN_ONE   = 3'd0;
  localparam logic [2:0] LEN_TWO   = 3'd1;
  localparam logic [2:0] LEN_FOUR  = 3'd2;
  localparam logic [2:0] LEN_EIGHT = 3'd3;
  localparam logic [2:0] LEN_PAGE  = 3'd7;

  typedef struct packed {
    logic [2:0] len;
    logic       ilv;
  } bcg_mode_t;

  localparam bcg_mode_t MODE_RESET = '{len: LEN_ONE, ilv: 1'b0};

  // Number of low column bits that wrap for a fixed-length code
  function automatic int unsigned wrap_bits(input logic [2:0] code);
    case (code)
      LEN_TWO:   return 1;
      LEN_FOUR:  return 2;
      LEN_EIGHT: return 3;
      default:   return 0;
    endcase
  endfunction

endpackage

// File: rtl/bcg_mode_reg.sv
module bcg_mode_reg
  import bcg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      mode_set_i,
  input  logic [2:0] mode_len_i,
  input  logic      mode_ilv_i,
  output bcg_mode_t mode_o
);

  bcg_mode_t mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RESET;
    end else if (mode_set_i) begin
      mode_q.len <= mode_len_i;
      mode_q.ilv <= mode_ilv_i;
    end
  end

  assign mode_o = mode_q;

  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_set_i |=> $stable(mode_q));

  // R2
  mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_set_i |=> (mode_q.len == $past(mode_len_i)) && (mode_q.ilv == $past(mode_ilv_i)));

endmodule

// File: rtl/bcg_beat_ctrl.sv
module bcg_beat_ctrl
  import bcg_pkg::*;
#(
  parameter int unsigned COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  bcg_mode_t        mode_i,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic             term_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic             last_o,
  output logic [COL_W-1:0] base_o,
  output logic [COL_W-1:0] beat_o,
  output logic [COL_W-1:0] mask_o,
  output logic             page_o,
  output logic             ilv_o
);

  localparam logic [COL_W-1:0] ALL_ONES = {COL_W{1'b1}};
  localparam logic [COL_W-1:0] ONE      = COL_W'(1);

  logic             valid_q;
  logic [COL_W-1:0] cnt_q;
  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] mask_q;
  logic             page_q;
  logic             ilv_q;

  logic [COL_W-1:0] mask_d;
  logic             page_d;
  logic             fire;
  logic             last;
  logic             page_stop;

  // Burst configuration decoded from the captured mode
  always_comb begin
    page_d = (mode_i.len == LEN_PAGE);
    if (page_d) mask_d = ALL_ONES;
    else        mask_d = (ONE << wrap_bits(mode_i.len)) - ONE;
  end

  assign fire      = valid_q && ready_i;
  assign last      = valid_q && !page_q && (cnt_q == mask_q);
  assign page_stop = valid_q && page_q && term_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      cnt_q   <= '0;
      base_q  <= '0;
      mask_q  <= '0;
      page_q  <= 1'b0;
      ilv_q   <= 1'b0;
    end else if (start_i) begin
      valid_q <= 1'b1;
      cnt_q   <= '0;
      base_q  <= start_col_i;
      mask_q  <= mask_d;
      page_q  <= page_d;
      ilv_q   <= mode_i.ilv;
    end else if (page_stop) begin
      valid_q <= 1'b0;
    end else if (fire) begin
      if (last) valid_q <= 1'b0;
      else      cnt_q   <= cnt_q + ONE;
    end
  end

  assign valid_o = valid_q;
  assign last_o  = last;
  assign base_o  = base_q;
  assign beat_o  = cnt_q;
  assign mask_o  = mask_q;
  assign page_o  = page_q;
  assign ilv_o   = ilv_q;

  // R7
  last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> valid_o);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q && !ready_i && !start_i && !(page_q && term_i)
    |=> valid_q && $stable(cnt_q) && $stable(base_q) && $stable(last_o));

  // R7
  end_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q && ready_i && last_o && !start_i |=> !valid_q);

  // R9
  page_no_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q && page_q |-> !last_o);

  // R10
  term_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q && page_q && term_i && !start_i |=> !valid_q);

  // R10
  term_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q && !page_q && term_i && !ready_i && !start_i |=> valid_q);

  // R11
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> valid_q && (cnt_q == '0));

endmodule

// File: rtl/bcg_addr_map.sv
module bcg_addr_map #(
  parameter int unsigned COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_i,
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             page_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] addr_o
);

  logic [COL_W-1:0] sum_w;
  logic [COL_W-1:0] flip_w;
  logic             use_flip;

  assign sum_w    = base_i + beat_i;
  assign flip_w   = base_i ^ beat_i;
  assign use_flip = ilv_i && !page_i;

  // Per bit: wrapping bits follow the order, the rest keep the start column
  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    assign addr_o[i] = mask_i[i] ? (use_flip ? flip_w[i] : sum_w[i]) : base_i[i];
  end

  // R5
  ilv_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && use_flip |-> ((addr_o ^ base_i) == beat_i));

  // R4
  seq_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && !use_flip
    |-> (((addr_o - base_i) & mask_i) == (beat_i & mask_i))
        && (((addr_o ^ base_i) & ~mask_i) == '0));

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import bcg_pkg::*;
#(
  parameter int unsigned COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_set_i,
  input  logic [2:0]       mode_len_i,
  input  logic             mode_ilv_i,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic             term_i,
  output logic             col_valid_o,
  input  logic             col_ready_i,
  output logic [COL_W-1:0] col_addr_o,
  output logic             col_last_o
);

  bcg_mode_t        mode_w;
  logic [COL_W-1:0] base_w;
  logic [COL_W-1:0] beat_w;
  logic [COL_W-1:0] mask_w;
  logic             page_w;
  logic             ilv_w;

  bcg_mode_reg i_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_set_i (mode_set_i),
    .mode_len_i (mode_len_i),
    .mode_ilv_i (mode_ilv_i),
    .mode_o     (mode_w)
  );

  bcg_beat_ctrl #(.COL_W(COL_W)) i_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode_w),
    .start_i     (start_i),
    .start_col_i (start_col_i),
    .term_i      (term_i),
    .ready_i     (col_ready_i),
    .valid_o     (col_valid_o),
    .last_o      (col_last_o),
    .base_o      (base_w),
    .beat_o      (beat_w),
    .mask_o      (mask_w),
    .page_o      (page_w),
    .ilv_o       (ilv_w)
  );

  bcg_addr_map #(.COL_W(COL_W)) i_map (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_i (col_valid_o),
    .base_i  (base_w),
    .beat_i  (beat_w),
    .mask_i  (mask_w),
    .page_i  (page_w),
    .ilv_i   (ilv_w),
    .addr_o  (col_addr_o)
  );

  // R3
  start_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> col_valid_o && (col_addr_o == $past(start_col_i)));

  // R8
  stall_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid_o && !col_ready_i && !start_i && !term_i |=> $stable(col_addr_o));

endmodule

// File: tb/test_burst_col_gen.sv
module test_burst_col_gen;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_set_i = 1'b0;
  logic [2:0] mode_len_i = '0;
  logic       mode_ilv_i = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] start_col_i = '0;
  logic       term_i = 1'b0;
  logic       col_valid_o;
  logic       col_ready_i = 1'b1;
  logic [7:0] col_addr_o;
  logic       col_last_o;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_col_gen i_burst_col_gen (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_set_i  (mode_set_i),
    .mode_len_i  (mode_len_i),
    .mode_ilv_i  (mode_ilv_i),
    .start_i     (start_i),
    .start_col_i (start_col_i),
    .term_i      (term_i),
    .col_valid_o (col_valid_o),
    .col_ready_i (col_ready_i),
    .col_addr_o  (col_addr_o),
    .col_last_o  (col_last_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int model_addr(input int base, input int n, input int bl, input bit ilv);
    if (bl == 256) return (base + n) % 256;
    if (ilv) return base ^ n;
    return (base / bl) * bl + ((base % bl) + n) % bl;
  endfunction

  task automatic set_mode(input logic [2:0] len, input logic ilv);
    @(negedge clk);
    mode_len_i = len; mode_ilv_i = ilv; mode_set_i = 1'b1;
    @(negedge clk);
    mode_set_i = 1'b0;
  endtask

  // Runs one burst; bl=256 means full page, ended by terminate after 'beats'
  task automatic run_burst(input int col, input int bl, input bit ilv, input int beats,
                           input int stall_beat, input int term_beat, input string req);
    int k = 0;
    int st = 0;
    @(negedge clk);
    start_i = 1'b1; start_col_i = 8'(col); col_ready_i = 1'b1;
    while (k < beats) begin
      int seen = k;
      @(negedge clk);
      start_i = 1'b0;
      chk({req, " valid"}, int'(col_valid_o), 1);
      chk({req, " addr"}, int'(col_addr_o), model_addr(col, k, bl, ilv));
      chk({req, " last"}, int'(col_last_o), int'(bl != 256 && k == bl - 1));
      if (k == stall_beat && st < 2) begin
        col_ready_i = 1'b0; st++;
      end else begin
        col_ready_i = 1'b1; k++;
      end
      if (bl == 256) term_i = (k == beats);
      else           term_i = (seen == term_beat);
    end
    @(negedge clk);
    term_i = 1'b0; col_ready_i = 1'b1;
    chk({req, " idle after burst"}, int'(col_valid_o), 0);
  endtask

  task automatic t_reset();
    chk("R1 valid", int'(col_valid_o), 0);
    chk("R1 last", int'(col_last_o), 0);
    run_burst(8'h5C, 1, 0, 1, -1, -1, "R1 default length one");
  endtask

  task automatic t_sequential();
    set_mode(3'd2, 1'b0);
    run_burst(8'h35, 4, 0, 4, -1, -1, "R4 seq BL4");
    set_mode(3'd3, 1'b0);
    run_burst(8'h3D, 8, 0, 8, -1, -1, "R4 seq BL8");
  endtask

  task automatic t_interleave();
    set_mode(3'd3, 1'b1);
    run_burst(8'h3D, 8, 1, 8, -1, -1, "R5 ilv BL8");
    set_mode(3'd1, 1'b1);
    run_burst(8'hA7, 2, 1, 2, -1, -1, "R5 ilv BL2");
    set_mode(3'd2, 1'b1);
    run_burst(8'h62, 4, 1, 4, -1, -1, "R5 ilv BL4");
  endtask

  task automatic t_single();
    set_mode(3'd0, 1'b0);
    run_burst(8'hC3, 1, 0, 1, -1, -1, "R6 BL1 seq");
    set_mode(3'd0, 1'b1);
    run_burst(8'hC3, 1, 1, 1, -1, -1, "R6 BL1 ilv");
  endtask

  task automatic t_page();
    set_mode(3'd7, 1'b1);
    run_burst(8'hFD, 256, 0, 6, -1, -1, "R9 page wrap");
  endtask

  task automatic t_stall();
    set_mode(3'd2, 1'b0);
    run_burst(8'h11, 4, 0, 4, 1, -1, "R8 stall");
    set_mode(3'd7, 1'b0);
    run_burst(8'h40, 256, 0, 3, 2, -1, "R8 page stall");
  endtask

  task automatic t_term_fixed();
    set_mode(3'd2, 1'b0);
    run_burst(8'h26, 4, 0, 4, -1, 1, "R10 terminate ignored");
  endtask

  task automatic t_mode_latch();
    set_mode(3'd1, 1'b0);
    @(negedge clk);
    mode_len_i = 3'd3; mode_ilv_i = 1'b1;
    run_burst(8'h47, 2, 0, 2, -1, -1, "R2 pins without strobe");
    set_mode(3'd5, 1'b1);
    run_burst(8'h9A, 1, 0, 1, -1, -1, "R2 reserved code");
  endtask

  task automatic t_restart();
    set_mode(3'd7, 1'b0);
    @(negedge clk);
    start_i = 1'b1; start_col_i = 8'h80;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      start_i = 1'b0;
      chk("R11 first burst addr", int'(col_addr_o), 8'h80 + k);
    end
    start_i = 1'b1; start_col_i = 8'h10; term_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; term_i = 1'b0;
    chk("R11 restart valid", int'(col_valid_o), 1);
    chk("R11 restart addr", int'(col_addr_o), 8'h10);
    @(negedge clk);
    chk("R11 restart step", int'(col_addr_o), 8'h11);
    term_i = 1'b1;
    @(negedge clk);
    term_i = 1'b0;
    chk("R10 page terminated", int'(col_valid_o), 0);
    set_mode(3'd3, 1'b0);
    @(negedge clk);
    start_i = 1'b1; start_col_i = 8'h20;
    @(negedge clk);
    @(negedge clk);
    start_i = 1'b1; start_col_i = 8'h4E;
    @(negedge clk);
    start_i = 1'b0;
    chk("R11 fixed restart addr", int'(col_addr_o), 8'h4E);
    chk("R11 fixed restart last", int'(col_last_o), 0);
    @(negedge clk);
    chk("R11 fixed restart wrap", int'(col_addr_o), 8'h4F);
    @(negedge clk);
    chk("R11 fixed restart wrap", int'(col_addr_o), 8'h48);
    repeat (6) @(negedge clk);
    chk("R11 fixed restart done", int'(col_valid_o), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: got hang expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sequential();
    t_interleave();
    t_single();
    t_page();
    t_stall();
    t_term_fixed();
    t_mode_latch();
    t_restart();
    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule